// File: doc/BRIEF.md
# Iteration Schedule Shape Configurator

This block turns a compact schedule request into the programming for a vector loop. The request holds three 5-bit dimension fields (x, y, z), a 4-bit schedule mode and a vertical-first flag. The block works out how many elements the schedule will visit. It fills four 32-bit shape registers with the dimension, permute, skip, sub-mode and inversion codes that a later address-remapping stage reads. It also rewrites the 64-bit vector-state word. Both the shape registers and the state word use MSB-0 bit numbering, so bit 0 is the most significant bit.

The supported schedules are matrix multiply, the FFT butterfly, the DCT and inverse-DCT inner and outer butterflies, cosine-table generation and half-swap reordering. Several length formulas depend on the run of one bits at the low end of x. The block evaluates that run with a small iterative engine that takes one loop step per clock. A caller pulses `start_i` with the request and the current state word, then waits for the single-cycle `done_o` pulse. After that pulse the new state word and the four shapes stay on the outputs until the next request completes.

Top module: `sched_shape_cfg`

## Requirements
- R1: While reset is held and after it is released, `busy_o` and `done_o` are 0, and `state_o` and all four shapes read zero until the first request completes.
- R2: A `start_i` sampled while idle captures the request and raises `busy_o`. Let k be the number of consecutive one bits of x counted upward from bit 0, at most 5. `done_o` is high for exactly one cycle, on the (k+2)-th rising edge counting the one that sampled `start_i`, and at that point `busy_o` is back to 0. A `start_i` or input change while busy has no effect on the result.
- R3: The completed state word starts from the captured `state_i`, with MSB-0 bits 0..31 cleared. If the persistence bit (MSB-0 bit 62, LSB bit 1) of the captured word is 0, MSB-0 bits 32..46, 62 and 63 are also cleared. All other bits keep their captured values.
- R4: In the completed state word, MSB-0 bits 0..6 (the maximum length) and bits 7..13 (the length) both hold the computed 7-bit length L, and MSB-0 bit 63 holds the captured vf.
- R5: Shape fields, MSB-0 within each 32-bit shape: xdim 0..5, ydim 6..11, zdim 12..17, permute 18..20, inversion 21..23, skip 28..29, mode 30..31. The remaining bits are zero. Mode 0000 gives L = (x*y*z) mod 128. The base shape has xdim=x, ydim=y, zdim=z and skip=11. Shapes 0 and 3 equal the base. Shape 1 is the base with permute 001 and skip 01. Shape 2 is the base with permute 001 and skip 11.
- R6: Mode 0001 (FFT) gives L = ((x+1)*k) mod 128. The base has xdim=x and mode=01. Shape 0 is the base, shape 1 is the base with skip 01, shape 2 is the base with skip 10, and shape 3 is zero.
- R7: Modes 0010, 0100, 1010 and 1100 (inner butterfly) give L = ((x+1)*k) mod 128. The base has xdim=x. When mode bit 3 is set, the base has mode=11 and permute=011. When it is clear, the base has mode=01, permute=001 and inversion=001. The base has ydim=3 when mode bit 2 is set and ydim=1 otherwise. Shape 0 is the base with skip 01, shape 1 is the base, and shape 2 is the base with skip 10. Shape 3 is the base with skip 11, or zero when mode bit 2 is set.
- R8: Modes 0011 and 1011 (outer butterfly) start with c = (x+1)>>1 and s = 1. For k steps, each step adds (c-1)*s to L, doubles s and halves c, with L taken mod 128. The base has xdim=x and ydim=2. For 1011 the base has mode=11, permute=011 and inversion=101. For 0011 it has mode=01 and permute=100. Shapes 0 and 2 are the base, shape 1 is the base with skip 01, and shape 3 is zero.
- R9: Modes 0101 and 1101 (cosine table) start with c = (x+1)>>1. For k steps, each step adds c to L and then halves c. The base has xdim=x, mode=01 and ydim=4, with inversion=001 only for 0101. Shape 0 is the base, shape 1 is the base with skip 10, shape 2 is the base with skip 11, and shape 3 is zero.
- R10: Modes 0110, 1110 and 1111 (half-swap) give L = x+1. Shape 0 has xdim=x, ydim=5, and mode=01 for 1111 or mode=11 otherwise. Only 1110 sets permute=001. Shapes 1..3 are zero.
- R11: Modes 0111, 1000 and 1001 give L = 0 and leave all four shapes zero.
- R12: Between completions, `state_o` and all shapes hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| mode_i | input | 4 | Schedule mode |
| xdim_i | input | 5 | x dimension field |
| ydim_i | input | 5 | y dimension field |
| zdim_i | input | 5 | z dimension field |
| vf_i | input | 1 | Vertical-first flag written to state bit 63 |
| state_i | input | 64 | Current vector-state word (MSB-0) |
| busy_o | output | 1 | High while the length loop runs |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 64 | Updated vector-state word |
| shapes_o | output | 4x32 | Shape registers, element g is shape g |

## Verification
Assertions check on every cycle that `done_o` is a single-cycle pulse seen only when the block is idle. They also check that the loop counter never passes five and advances by one per busy cycle, that the outputs never move outside a completion, that the two length fields agree and the cleared range stays zero, and that bit 63 matches the captured flag. The actual length values, the per-mode shape codes, the persistence-dependent clearing and the fact that a mid-run restart is ignored can only be shown by the bench scenarios. These sweep every mode against every x value, with varied y, z, flag and state words, and compare each result with arithmetic computed in the bench.

// File: rtl/sched_cfg_pkg.sv
package sched_cfg_pkg;

    localparam int DIM_W      = 5;
    localparam int LEN_W      = 7;
    localparam int MODE_W     = 4;
    localparam int SHAPE_W    = 32;
    localparam int NUM_SHAPES = 4;
    localparam int STATE_W    = 64;
    localparam int FLD_W      = 6;

    // MSB-0 field positions inside a shape word
    localparam int F_XDIM = 0;
    localparam int F_YDIM = 6;
    localparam int F_ZDIM = 12;
    localparam int F_PERM = 18;
    localparam int F_INV  = 21;
    localparam int F_SKIP = 28;
    localparam int F_MODE = 30;

    localparam int W_DIM  = 6;
    localparam int W_CODE = 3;
    localparam int W_SEL  = 2;

    typedef logic [SHAPE_W-1:0]        shape_t;
    typedef shape_t [NUM_SHAPES-1:0]   shape_set_t;

    typedef enum logic [2:0] {
        SC_NONE,
        SC_MATMUL,
        SC_FFT,
        SC_INNER,
        SC_OUTER,
        SC_COS,
        SC_HSWAP
    } sched_class_e;

    function automatic sched_class_e classify(input logic [MODE_W-1:0] m);
        sched_class_e c;
        case (m)
            4'b0000:                            c = SC_MATMUL;
            4'b0001:                            c = SC_FFT;
            4'b0010, 4'b0100, 4'b1010, 4'b1100: c = SC_INNER;
            4'b0011, 4'b1011:                   c = SC_OUTER;
            4'b0101, 4'b1101:                   c = SC_COS;
            4'b0110, 4'b1110, 4'b1111:          c = SC_HSWAP;
            default:                            c = SC_NONE;
        endcase
        return c;
    endfunction

    // Write a field of w bits whose MSB-0 start index is pos
    function automatic shape_t put_field(input shape_t s, input int unsigned pos,
                                         input int unsigned w, input logic [FLD_W-1:0] v);
        shape_t r;
        r = s;
        for (int i = 0; i < FLD_W; i++) begin
            if (i < int'(w)) begin
                r[SHAPE_W - int'(pos) - int'(w) + i] = v[i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sched_len_engine.sv
module sched_len_engine #(
    parameter int DIM_W = 5,
    parameter int LEN_W = 7,
    parameter int CNT_W = $clog2(DIM_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [DIM_W-1:0] x_i,
    output logic             busy_o,
    output logic             fin_o,
    output logic [CNT_W-1:0] run_o,
    output logic [LEN_W-1:0] outer_o,
    output logic [LEN_W-1:0] cos_o
);

    localparam logic [CNT_W-1:0] MAX_STEPS = CNT_W'(DIM_W);

    logic [DIM_W-1:0] x_q;
    logic [CNT_W-1:0] step_q;
    logic [LEN_W-1:0] ic_q;
    logic [LEN_W-1:0] size_q;
    logic [LEN_W-1:0] outer_q;
    logic [LEN_W-1:0] cos_q;
    logic             busy_q;
    logic [DIM_W-1:0] x_shift;
    logic             cont;

    assign x_shift = x_q >> step_q;
    assign cont    = busy_q && (step_q < MAX_STEPS) && x_shift[0];
    assign fin_o   = busy_q && !cont;
    assign busy_o  = busy_q;
    assign run_o   = step_q;
    assign outer_o = outer_q;
    assign cos_o   = cos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            x_q     <= '0;
            step_q  <= '0;
            ic_q    <= '0;
            size_q  <= '0;
            outer_q <= '0;
            cos_q   <= '0;
        end else if (!busy_q && start_i) begin
            busy_q  <= 1'b1;
            x_q     <= x_i;
            step_q  <= '0;
            ic_q    <= (LEN_W'(x_i) + LEN_W'(1)) >> 1;
            size_q  <= LEN_W'(1);
            outer_q <= '0;
            cos_q   <= '0;
        end else if (cont) begin
            step_q  <= step_q + CNT_W'(1);
            outer_q <= outer_q + (ic_q - LEN_W'(1)) * size_q;
            cos_q   <= cos_q + ic_q;
            ic_q    <= ic_q >> 1;
            size_q  <= size_q << 1;
        end else if (fin_o) begin
            busy_q  <= 1'b0;
        end
    end

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (step_q <= MAX_STEPS)); // R2

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !fin_o) |=> (busy_q && step_q == $past(step_q) + CNT_W'(1))); // R2

    AST_FIN_RELEASES: assert property (@(posedge clk) disable iff (rst)
        fin_o |=> !busy_q); // R2

endmodule

// File: rtl/sched_shape_table.sv
module sched_shape_table
    import sched_cfg_pkg::*;
#(
    parameter int DIM_W  = sched_cfg_pkg::DIM_W,
    parameter int MODE_W = sched_cfg_pkg::MODE_W
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic [DIM_W-1:0]  x_i,
    input  logic [DIM_W-1:0]  y_i,
    input  logic [DIM_W-1:0]  z_i,
    output shape_set_t        shapes_o
);

    sched_class_e cls;
    shape_t       base;
    logic         inv_sel;
    logic         otf_sel;

    assign cls     = classify(mode_i);
    assign inv_sel = mode_i[MODE_W-1];
    assign otf_sel = mode_i[MODE_W-2];

    always_comb begin
        shapes_o = '0;
        base     = put_field('0, F_XDIM, W_DIM, FLD_W'(x_i));
        case (cls)
            SC_MATMUL: begin
                base = put_field(base, F_YDIM, W_DIM, FLD_W'(y_i));
                base = put_field(base, F_ZDIM, W_DIM, FLD_W'(z_i));
                base = put_field(base, F_SKIP, W_SEL, 6'd3);
                shapes_o[0] = base;
                shapes_o[3] = base;
                shapes_o[1] = put_field(put_field(base, F_PERM, W_CODE, 6'd1), F_SKIP, W_SEL, 6'd1);
                shapes_o[2] = put_field(put_field(base, F_PERM, W_CODE, 6'd1), F_SKIP, W_SEL, 6'd3);
            end
            SC_FFT: begin
                base = put_field(base, F_MODE, W_SEL, 6'd1);
                shapes_o[0] = base;
                shapes_o[1] = put_field(base, F_SKIP, W_SEL, 6'd1);
                shapes_o[2] = put_field(base, F_SKIP, W_SEL, 6'd2);
            end
            SC_INNER: begin
                if (inv_sel) begin
                    base = put_field(base, F_MODE, W_SEL, 6'd3);
                    base = put_field(base, F_PERM, W_CODE, 6'd3);
                end else begin
                    base = put_field(base, F_MODE, W_SEL, 6'd1);
                    base = put_field(base, F_PERM, W_CODE, 6'd1);
                    base = put_field(base, F_INV, W_CODE, 6'd1);
                end
                base = put_field(base, F_YDIM, W_DIM, otf_sel ? 6'd3 : 6'd1);
                shapes_o[0] = put_field(base, F_SKIP, W_SEL, 6'd1);
                shapes_o[1] = base;
                shapes_o[2] = put_field(base, F_SKIP, W_SEL, 6'd2);
                if (!otf_sel) begin
                    shapes_o[3] = put_field(base, F_SKIP, W_SEL, 6'd3);
                end
            end
            SC_OUTER: begin
                if (inv_sel) begin
                    base = put_field(base, F_MODE, W_SEL, 6'd3);
                    base = put_field(base, F_PERM, W_CODE, 6'd3);
                    base = put_field(base, F_INV, W_CODE, 6'd5);
                end else begin
                    base = put_field(base, F_MODE, W_SEL, 6'd1);
                    base = put_field(base, F_PERM, W_CODE, 6'd4);
                end
                base = put_field(base, F_YDIM, W_DIM, 6'd2);
                shapes_o[0] = base;
                shapes_o[1] = put_field(base, F_SKIP, W_SEL, 6'd1);
                shapes_o[2] = base;
            end
            SC_COS: begin
                base = put_field(base, F_MODE, W_SEL, 6'd1);
                base = put_field(base, F_YDIM, W_DIM, 6'd4);
                if (!inv_sel) begin
                    base = put_field(base, F_INV, W_CODE, 6'd1);
                end
                shapes_o[0] = base;
                shapes_o[1] = put_field(base, F_SKIP, W_SEL, 6'd2);
                shapes_o[2] = put_field(base, F_SKIP, W_SEL, 6'd3);
            end
            SC_HSWAP: begin
                if (mode_i == 4'b1110) begin
                    base = put_field(base, F_PERM, W_CODE, 6'd1);
                end
                base = put_field(base, F_MODE, W_SEL, (mode_i == 4'b1111) ? 6'd1 : 6'd3);
                base = put_field(base, F_YDIM, W_DIM, 6'd5);
                shapes_o[0] = base;
            end
            default: begin
                shapes_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/sched_state_merge.sv
module sched_state_merge #(
    parameter int LEN_W   = 7,
    parameter int STATE_W = 64
) (
    input  logic [STATE_W-1:0] prev_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               vf_i,
    output logic [STATE_W-1:0] next_o
);

    localparam int LOW_CLR_N   = 32;
    localparam int REMAP_FIRST = 32;
    localparam int REMAP_LAST  = 46;
    localparam int PERSIST_BIT = STATE_W - 1 - 62;
    localparam int VF_BIT      = STATE_W - 1 - 63;
    localparam int MAXLEN_HI   = STATE_W - 1;
    localparam int LEN_HI      = STATE_W - 1 - LEN_W;

    always_comb begin
        next_o = prev_i;
        for (int b = 0; b < LOW_CLR_N; b++) begin
            next_o[STATE_W-1-b] = 1'b0;
        end
        if (!prev_i[PERSIST_BIT]) begin
            for (int b = REMAP_FIRST; b <= REMAP_LAST; b++) begin
                next_o[STATE_W-1-b] = 1'b0;
            end
            next_o[PERSIST_BIT] = 1'b0;
        end
        next_o[MAXLEN_HI -: LEN_W] = len_i;
        next_o[LEN_HI -: LEN_W]    = len_i;
        next_o[VF_BIT]             = vf_i;
    end

endmodule

// File: rtl/sched_shape_cfg.sv
module sched_shape_cfg
    import sched_cfg_pkg::*;
#(
    parameter int DIM_W   = sched_cfg_pkg::DIM_W,
    parameter int LEN_W   = sched_cfg_pkg::LEN_W,
    parameter int MODE_W  = sched_cfg_pkg::MODE_W,
    parameter int STATE_W = sched_cfg_pkg::STATE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic [DIM_W-1:0]    xdim_i,
    input  logic [DIM_W-1:0]    ydim_i,
    input  logic [DIM_W-1:0]    zdim_i,
    input  logic                vf_i,
    input  logic [STATE_W-1:0]  state_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [STATE_W-1:0]  state_o,
    output shape_set_t          shapes_o
);

    localparam int CNT_W = $clog2(DIM_W + 1);

    logic [MODE_W-1:0]  mode_q;
    logic [DIM_W-1:0]   x_q;
    logic [DIM_W-1:0]   y_q;
    logic [DIM_W-1:0]   z_q;
    logic               vf_q;
    logic [STATE_W-1:0] st_q;

    logic               busy;
    logic               fin;
    logic [CNT_W-1:0]   run_cnt;
    logic [LEN_W-1:0]   outer_len;
    logic [LEN_W-1:0]   cos_len;
    logic [LEN_W-1:0]   xp1;
    logic [LEN_W-1:0]   len_d;
    sched_class_e       cls;
    shape_set_t         tmpl;
    logic [STATE_W-1:0] st_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            vf_q   <= 1'b0;
            st_q   <= '0;
        end else if (start_i && !busy) begin
            mode_q <= mode_i;
            x_q    <= xdim_i;
            y_q    <= ydim_i;
            z_q    <= zdim_i;
            vf_q   <= vf_i;
            st_q   <= state_i;
        end
    end

    sched_len_engine #(
        .DIM_W (DIM_W),
        .LEN_W (LEN_W),
        .CNT_W (CNT_W)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .x_i     (xdim_i),
        .busy_o  (busy),
        .fin_o   (fin),
        .run_o   (run_cnt),
        .outer_o (outer_len),
        .cos_o   (cos_len)
    );

    assign cls = classify(mode_q);
    assign xp1 = LEN_W'(x_q) + LEN_W'(1);

    always_comb begin
        case (cls)
            SC_MATMUL:        len_d = LEN_W'(x_q) * LEN_W'(y_q) * LEN_W'(z_q);
            SC_FFT, SC_INNER: len_d = xp1 * LEN_W'(run_cnt);
            SC_OUTER:         len_d = outer_len;
            SC_COS:           len_d = cos_len;
            SC_HSWAP:         len_d = xp1;
            default:          len_d = '0;
        endcase
    end

    sched_shape_table #(
        .DIM_W  (DIM_W),
        .MODE_W (MODE_W)
    ) u_table (
        .mode_i   (mode_q),
        .x_i      (x_q),
        .y_i      (y_q),
        .z_i      (z_q),
        .shapes_o (tmpl)
    );

    sched_state_merge #(
        .LEN_W   (LEN_W),
        .STATE_W (STATE_W)
    ) u_merge (
        .prev_i (st_q),
        .len_i  (len_d),
        .vf_i   (vf_q),
        .next_o (st_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_o   <= 1'b0;
            state_o  <= '0;
            shapes_o <= '0;
        end else begin
            done_o <= fin;
            if (fin) begin
                state_o  <= st_next;
                shapes_o <= tmpl;
            end
        end
    end

    assign busy_o = busy;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R2

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(state_o) && $stable(shapes_o))); // R12

    AST_LEN_PAIR: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (state_o[STATE_W-1 -: LEN_W] == state_o[STATE_W-1-LEN_W -: LEN_W])); // R4

    AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (state_o[STATE_W-1-2*LEN_W : STATE_W-32] == '0)); // R3

    AST_VF_COPY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (state_o[0] == vf_q)); // R4

endmodule

// File: tb/sched_shape_cfg_tb.sv
module sched_shape_cfg_tb;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [4:0]    xd = '0;
    logic [4:0]    yd = '0;
    logic [4:0]    zd = '0;
    logic          vf = 1'b0;
    logic [63:0]   st_in = '0;
    logic          busy;
    logic          done;
    logic [63:0]   st_out;
    logic [3:0][31:0] shp;

    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    sched_shape_cfg u_dut (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .mode_i   (mode),
        .xdim_i   (xd),
        .ydim_i   (yd),
        .zdim_i   (zd),
        .vf_i     (vf),
        .state_i  (st_in),
        .busy_o   (busy),
        .done_o   (done),
        .state_o  (st_out),
        .shapes_o (shp)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ones_run(input int x);
        int k = 0;
        while (k < 5 && ((x >> k) & 1) == 1) k++;
        return k;
    endfunction

    function automatic int ref_len(input int m, input int x, input int y, input int z);
        int k  = ones_run(x);
        int ic = (x + 1) / 2;
        int sz = 1;
        int acc = 0;
        case (m)
            0:               return (x * y * z) % 128;
            1, 2, 4, 10, 12: return ((x + 1) * k) % 128;
            3, 11: begin
                for (int i = 0; i < k; i++) begin
                    acc += (ic - 1) * sz;
                    sz  *= 2;
                    ic  /= 2;
                end
                return acc % 128;
            end
            5, 13: begin
                for (int i = 0; i < k; i++) begin
                    acc += ic;
                    ic  /= 2;
                end
                return acc % 128;
            end
            6, 14, 15:       return x + 1;
            default:         return 0;
        endcase
    endfunction

    function automatic logic [31:0] bput(input logic [31:0] s, input int pos, input int w,
                                         input int v);
        int lsb = 32 - pos - w;
        logic [31:0] mask = ((32'd1 << w) - 32'd1) << lsb;
        return (s & ~mask) | ((32'(v) << lsb) & mask);
    endfunction

    function automatic logic [3:0][31:0] ref_shapes(input int m, input int x, input int y,
                                                    input int z);
        logic [3:0][31:0] r = '0;
        logic [31:0] b = bput(32'd0, 0, 6, x);
        case (m)
            0: begin
                b = bput(bput(bput(b, 6, 6, y), 12, 6, z), 28, 2, 3);
                r[0] = b; r[3] = b;
                r[1] = bput(bput(b, 18, 3, 1), 28, 2, 1);
                r[2] = bput(b, 18, 3, 1);
            end
            1: begin
                b = bput(b, 30, 2, 1);
                r[0] = b; r[1] = bput(b, 28, 2, 1); r[2] = bput(b, 28, 2, 2);
            end
            2, 4, 10, 12: begin
                if (m >= 8) b = bput(bput(b, 30, 2, 3), 18, 3, 3);
                else        b = bput(bput(bput(b, 30, 2, 1), 18, 3, 1), 21, 3, 1);
                b = bput(b, 6, 6, ((m & 4) != 0) ? 3 : 1);
                r[0] = bput(b, 28, 2, 1); r[1] = b; r[2] = bput(b, 28, 2, 2);
                if ((m & 4) == 0) r[3] = bput(b, 28, 2, 3);
            end
            3, 11: begin
                if (m == 11) b = bput(bput(bput(b, 30, 2, 3), 18, 3, 3), 21, 3, 5);
                else         b = bput(bput(b, 30, 2, 1), 18, 3, 4);
                b = bput(b, 6, 6, 2);
                r[0] = b; r[2] = b; r[1] = bput(b, 28, 2, 1);
            end
            5, 13: begin
                b = bput(bput(b, 30, 2, 1), 6, 6, 4);
                if (m == 5) b = bput(b, 21, 3, 1);
                r[0] = b; r[1] = bput(b, 28, 2, 2); r[2] = bput(b, 28, 2, 3);
            end
            6, 14, 15: begin
                b = bput(b, 6, 6, 5);
                b = bput(b, 30, 2, (m == 15) ? 1 : 3);
                if (m == 14) b = bput(b, 18, 3, 1);
                r[0] = b;
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic [63:0] ref_state(input logic [63:0] p, input int len,
                                              input logic f);
        logic [63:0] e = p;
        e[63:32] = '0;
        if (!p[1]) begin
            e[31:17] = '0;
            e[1] = 1'b0;
        end
        e[63:57] = 7'(len);
        e[56:50] = 7'(len);
        e[0] = f;
        return e;
    endfunction

    function automatic string req_of(input int m);
        case (m)
            0:               return "R5";
            1:               return "R6";
            2, 4, 10, 12:    return "R7";
            3, 11:           return "R8";
            5, 13:           return "R9";
            6, 14, 15:       return "R10";
            default:         return "R11";
        endcase
    endfunction

    task automatic do_run(input int m, input int x, input int y, input int z,
                          input logic f, input logic [63:0] p);
        int lat = 0;
        int len;
        logic [63:0] es;
        logic [3:0][31:0] eshp;
        mode = 4'(m); xd = 5'(x); yd = 5'(y); zd = 5'(z); vf = f; st_in = p;
        start = 1'b1;
        for (int c = 1; c <= 20; c++) begin
            @(negedge clk);
            if (done) begin
                lat = c;
                break;
            end
            if (c == 1) begin
                // restart attempt while busy, must be ignored (R2)
                mode = mode ^ 4'hF; xd = xd ^ 5'h1F; vf = ~vf; st_in = ~st_in;
            end
            if (c == 2) start = 1'b0;
        end
        start = 1'b0;
        check(lat == ones_run(x) + 2, "R2 latency", 128'(lat), 128'(ones_run(x) + 2));
        len  = ref_len(m, x, y, z);
        es   = ref_state(p, len, f);
        eshp = ref_shapes(m, x, y, z);
        check(st_out == es, "R3 R4 state", 128'(st_out), 128'(es));
        for (int g = 0; g < 4; g++) begin
            check(shp[g] == eshp[g], req_of(m), 128'(shp[g]), 128'(eshp[g]));
        end
        @(negedge clk);
        @(negedge clk);
        check(st_out == es && shp == eshp, "R12 hold", {st_out, 64'(shp[0])}, {es, 64'(eshp[0])});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R2 watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] seed = 64'h0123_4567_89AB_CDEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 flags", 128'({busy, done}), 128'(0));
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1 flags", 128'({busy, done}), 128'(0));
        check(st_out == '0, "R1 state", 128'(st_out), 128'(0));
        check(shp == '0, "R1 shapes", 128'(shp), 128'(0));
        for (int m = 0; m < 16; m++) begin
            for (int x = 0; x < 32; x++) begin
                seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
                do_run(m, x, (x * 7 + 3) % 32, (x * 13 + m) % 32, logic'((x + m) & 1),
                       seed ^ {seed[31:0], seed[63:32]});
            end
        end
        summary();
        $finish;
    end

endmodule